// File: doc/BRIEF.md
# TLB Random Replacement Index Generator

This block picks the slot that a random TLB write should replace. On a request it draws a pseudo-random index from the slots above the wired boundary: the range runs from the wired count up to the last entry. The draw comes from a 32-bit linear congruential seed. The block also remembers the index it last returned and never hands out the same index twice in a row, unless only one slot is free.

The seed step is a multiply-add that wraps at 32 bits. The upper half of the new seed is reduced modulo the window size by a sequential restoring divider, and the wired count is then added back. If that candidate equals the previous result, the seed steps again and the reduction repeats. When the window holds exactly one slot, the last entry is returned on the next cycle and the seed is left alone. The requester pulses a strobe and waits for a one-cycle valid pulse. Strobes that arrive while a draw is in progress are dropped.

Top module: `tlb_rand_idx`

## Requirements
- R1: After synchronous reset, `valid_o` = 0, `busy_o` = 0 and `idx_o` = 0. The internal seed is 1 and the remembered previous index is 0.
- R2: Every draw first replaces the seed with (seed * 1103515245 + 12345) mod 2^32.
- R3: With window size W = TLB_SIZE - wired, a draw yields the candidate ((new seed >> 16) mod W) + wired.
- R4: When W = 1, the result TLB_SIZE-1 appears with `valid_o` on the cycle after the accepted request, and the seed is not stepped.
- R5: A candidate equal to the previously returned index is discarded, and draws repeat (each one stepping the seed) until the candidate differs.
- R6: Each returned index becomes the remembered previous index, including a shortcut result.
- R7: `busy_o` is high from the cycle after an accepted non-shortcut request until the result. `valid_o` is never high while `busy_o` is high. `valid_o` is high for one cycle per result, and `idx_o` holds its value until the next result.
- R8: A request seen while `busy_o` is high is ignored, together with its `wired_i` value. It causes no extra result, and the seed and previous index are not changed by it.
- R9: Every returned index lies in [wired, TLB_SIZE-1] for the wired count latched at the accepted request. `wired_i` must be below TLB_SIZE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe for a new random index |
| wired_i | input | IDX_W | Count of wired (protected) low entries, sampled when a request is accepted |
| idx_o | output | IDX_W | Returned TLB index |
| valid_o | output | 1 | One-cycle pulse marking a new `idx_o` |
| busy_o | output | 1 | High while a draw is being computed |

## Verification
On every cycle the assertions check that a result stays inside the latched window and differs from the previous result whenever the window is wider than one slot. They also check that a one-slot request returns the last entry without stepping the seed, that `valid_o` never coincides with `busy_o`, and that the divider remainder is below the divisor. Only the bench scenarios can show that results follow the exact recurrence from the reset seed over long runs across several wired settings. The same holds for discarded repeats changing later draws, and for a dropped mid-draw request leaving no trace in the sequence that follows.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  localparam int SEED_W = 32;
  localparam int DRAW_W = SEED_W / 2;
  localparam logic [SEED_W-1:0] LCG_MUL   = 32'd1103515245;
  localparam logic [SEED_W-1:0] LCG_INC   = 32'd12345;
  localparam logic [SEED_W-1:0] SEED_INIT = 32'd1;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DRAW = 1'b1
  } rand_state_e;
endpackage

// File: rtl/tlb_lcg_step.sv
module tlb_lcg_step
  import tlb_rand_pkg::*;
(
  input  logic [SEED_W-1:0] seed_i,
  output logic [SEED_W-1:0] seed_o
);
  // Multiply-add, wrapping at the seed width
  always_comb begin
    seed_o = seed_i * LCG_MUL + LCG_INC;
  end
endmodule

// File: rtl/tlb_mod_div.sv
module tlb_mod_div #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [DEN_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;

  // one restoring step: bring in the next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem_q, num_q[NUM_W-1]};
    diff  = trial - {1'b0, den_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      num_q  <= num_i;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(NUM_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      num_q  <= num_q << 1;
      rem_q  <= diff[DEN_W] ? trial[DEN_W-1:0] : diff[DEN_W-1:0];
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign rem_o  = rem_q;

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (rem_q < den_i));
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_rand_pkg::*;
#(
  parameter int TLB_SIZE = 16,
  parameter int IDX_W    = $clog2(TLB_SIZE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [IDX_W-1:0] wired_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             busy_o
);
  localparam int RNG_W = $clog2(TLB_SIZE + 1);
  localparam logic [RNG_W-1:0] SIZE_C = RNG_W'(TLB_SIZE);
  localparam logic [IDX_W-1:0] LAST_C = IDX_W'(TLB_SIZE - 1);

  rand_state_e       state_q;
  logic [SEED_W-1:0] seed_q, seed_nx;
  logic [IDX_W-1:0]  wired_q, prev_q, idx_q;
  logic              valid_q;
  logic [RNG_W-1:0]  win_req, win_q;
  logic              accept, shortcut, div_start, div_done, take;
  logic [RNG_W-1:0]  div_rem;
  logic [IDX_W-1:0]  cand;

  tlb_lcg_step u_lcg (
    .seed_i (seed_q),
    .seed_o (seed_nx)
  );

  tlb_mod_div #(
    .NUM_W (DRAW_W),
    .DEN_W (RNG_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (div_start),
    .num_i   (seed_nx[SEED_W-1 -: DRAW_W]),
    .den_i   (win_q),
    .done_o  (div_done),
    .rem_o   (div_rem)
  );

  always_comb begin
    win_req   = SIZE_C - RNG_W'(wired_i);
    accept    = (state_q == ST_IDLE) && req_i;
    shortcut  = accept && (win_req == RNG_W'(1));
    cand      = IDX_W'(div_rem) + wired_q;
    take      = (state_q == ST_DRAW) && div_done && (cand != prev_q);
    div_start = (accept && !shortcut) ||
                ((state_q == ST_DRAW) && div_done && (cand == prev_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seed_q  <= SEED_INIT;
      wired_q <= '0;
      win_q   <= SIZE_C;
      prev_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (div_start) seed_q <= seed_nx;
      if (accept) begin
        wired_q <= wired_i;
        win_q   <= win_req;
      end
      if (shortcut) begin
        idx_q   <= LAST_C;
        prev_q  <= LAST_C;
        valid_q <= 1'b1;
      end else if (accept) begin
        state_q <= ST_DRAW;
      end
      if (take) begin
        idx_q   <= cand;
        prev_q  <= cand;
        valid_q <= 1'b1;
        state_q <= ST_IDLE;
      end
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
  assign busy_o  = (state_q == ST_DRAW);

  // R9
  window_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (idx_o >= wired_q));
  // R5
  no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && win_q != RNG_W'(1)) |-> (idx_o != $past(prev_q)));
  // R4
  shortcut_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && win_q == RNG_W'(1)) |-> (idx_o == LAST_C && seed_q == $past(seed_q)));
  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !valid_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !div_done) |=> $stable(wired_q));
endmodule

// File: tb/tlb_rand_idx_tb.sv
module tlb_rand_idx_tb;
  localparam int TLB_SIZE = 16;
  localparam int IDX_W    = $clog2(TLB_SIZE);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req = 1'b0;
  logic [IDX_W-1:0] wired = '0;
  logic [IDX_W-1:0] idx;
  logic             valid, busy;

  int n_tests = 0;
  int n_fail  = 0;
  int unsigned m_seed = 1;
  int          m_prev = 0;
  int          last_idx = 0;

  always #2.5 clk = ~clk;

  tlb_rand_idx #(.TLB_SIZE(TLB_SIZE)) u_dut (
    .clk (clk), .rst (rst), .req_i (req), .wired_i (wired),
    .idx_o (idx), .valid_o (valid), .busy_o (busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: R2 R3 R4 R5 R6
  function automatic int model_draw(input int w);
    int r, c;
    r = TLB_SIZE - w;
    if (r == 1) begin
      m_prev = TLB_SIZE - 1;
      return m_prev;
    end
    do begin
      m_seed = m_seed * 32'd1103515245 + 32'd12345;
      c = int'((m_seed >> 16) % r) + w;
    end while (c == m_prev);
    m_prev = c;
    return c;
  endfunction

  // one request; optional stray request while busy (R8)
  task automatic run_req(input int w, input bit stray, input int stray_w);
    int exp, cyc;
    bit seen;
    exp = model_draw(w);
    @(negedge clk);
    req = 1'b1; wired = IDX_W'(w);
    @(negedge clk);
    req = 1'b0;
    seen = 1'b0;
    cyc = 0;
    while (!seen && cyc < 2000) begin
      if (valid) begin
        seen = 1'b1;
        chk(idx == IDX_W'(exp), "R3/R5 index matches model", int'(idx), exp);
        chk(int'(idx) >= w && int'(idx) <= TLB_SIZE - 1, "R9 index in window", int'(idx), w);
        if (TLB_SIZE - w > 1)
          chk(int'(idx) != last_idx, "R5 differs from previous", int'(idx), last_idx);
        chk(!busy, "R7 busy low with valid", int'(busy), 0);
        if (TLB_SIZE - w == 1)
          chk(cyc == 0, "R4 shortcut latency", cyc, 0);
        last_idx = int'(idx);
      end else begin
        if (cyc == 0 && TLB_SIZE - w > 1)
          chk(busy, "R7 busy during draw", int'(busy), 1);
        if (stray && cyc == 3) begin
          req = 1'b1; wired = IDX_W'(stray_w);
          @(negedge clk);
          req = 1'b0;
          cyc++;
          continue;
        end
        @(negedge clk);
        cyc++;
      end
    end
    if (!seen) chk(1'b0, "R7 result timeout", cyc, 0);
    @(negedge clk);
    chk(!valid, "R7 valid is one cycle", int'(valid), 0);
    chk(idx == IDX_W'(exp), "R7 index held", int'(idx), exp);
    if (stray) begin
      for (int k = 0; k < 40; k++) begin
        if (valid || busy) begin
          chk(1'b0, "R8 stray request produced activity", int'(valid), 0);
          break;
        end
        @(negedge clk);
      end
      chk(!busy && !valid, "R8 stray request ignored", int'(busy), 0);
    end
  endtask

  initial begin
    #3_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!valid, "R1 valid after reset", int'(valid), 0);
    chk(!busy, "R1 busy after reset", int'(busy), 0);
    chk(idx == '0, "R1 index after reset", int'(idx), 0);
    // R2 R3 R6: full window, the first draw follows the reset seed
    for (int i = 0; i < 12; i++) run_req(0, 1'b0, 0);
    // mid windows
    for (int i = 0; i < 10; i++) run_req(5, 1'b0, 0);
    for (int i = 0; i < 8; i++)  run_req(11, 1'b0, 0);
    // R5: two-slot window forces alternation and discarded draws
    for (int i = 0; i < 8; i++)  run_req(14, 1'b0, 0);
    // R4: one-slot window, seed untouched, previous becomes last entry
    run_req(15, 1'b0, 0);
    run_req(15, 1'b0, 0);
    // R6: previous = 15 now steers the next two-slot draw to 14
    run_req(14, 1'b0, 0);
    run_req(15, 1'b0, 0);
    // R4: the seed was not stepped, so full-window draws stay in step
    for (int i = 0; i < 6; i++) run_req(0, 1'b0, 0);
    // R8: stray request with another wired value during a draw
    run_req(2, 1'b1, 9);
    run_req(2, 1'b1, 15);
    for (int i = 0; i < 5; i++) run_req(3, 1'b0, 0);
    // reset again: R1 seed and previous restored
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_seed = 1; m_prev = 0; last_idx = 0;
    chk(!valid && !busy && idx == '0, "R1 state after second reset", int'(idx), 0);
    for (int i = 0; i < 4; i++) run_req(0, 1'b0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule